// File: doc/BRIEF.md
# Phase-Shift Trigger Timing Controller

This block produces one reference trigger and three delayed triggers in every switching period. It is meant to be the timing core of a multi-leg phase-shifted converter. The period comes from one of two master sources. One is an external clock input, passed through a two-flop synchroniser. The other is an internal tick generator that pulses once every programmed number of system clock cycles. On every rising edge of the master the block does three things. It measures the period as the number of system cycles since the previous reference trigger. It samples the three setpoints. It emits the reference trigger.

Each setpoint is turned into a phase angle in whole degrees. The angle is the setpoint times a signed gain, plus an offset given by the phase-at-minimum bound. The gain's sign is corrected from the order of the two bounds. The bounds are capped at 359 degrees, and the result is clamped between them. Each delayed trigger fires once per period, `floor(period * phase / 360)` system cycles after the reference. Per-channel counters tally every trigger emitted.

All triggers are single-cycle strobes with no back-pressure: a consumer must take each pulse in the cycle it appears. Setpoints, gain and bounds are plain level inputs. Only their values at a master rising edge matter.

Top module: `pst_trigger_ctrl`

## Requirements
- R1: With `int_mode_i` = 1, reference triggers repeat every `period_cfg_i` system cycles (`period_cfg_i` >= 2). With `int_mode_i` = 0, they repeat at the period of `ext_clk_i`, which is sampled through two flip-flops.
- R2: Each master rising edge produces exactly one reference trigger, high for exactly one cycle.
- R3: The measured period equals the number of cycles between two consecutive reference triggers. Channel k's delayed trigger is high in the cycle that lies `floor(period * phase_k / 360)` cycles after the reference trigger of the same period. A phase of 0 coincides with the reference.
- R4: Setpoints are captured only at the master rising edge. A setpoint change inside a period does not move that period's delayed triggers; it takes effect from the next period.
- R5: The mapped phase is `setpt * gain + ph_min`, where setpoints are unsigned, the gain is two's-complement signed, and both bounds are first reduced to at most 359.
- R6: When the capped `ph_max` is above the capped `ph_min`, a negative gain is used as its magnitude. When it is below, a positive gain is negated.
- R7: The mapped phase is clamped to [ph_min, ph_max] for a non-negative effective gain, and to [ph_max, ph_min] for a negative one.
- R8: Each delayed trigger fires at most once between two reference triggers and is re-armed by each reference trigger.
- R9: `trig_cnt_o[0]` counts reference triggers. `trig_cnt_o[k]`, for k = 1..3, counts the triggers of `dly_trig_o[k-1]`. Each pulse adds exactly one, and the counters wrap.
- R10: Reset clears all timers, counters and armed flags and holds every trigger low. No delayed trigger appears before the first reference trigger after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External master clock, asynchronous |
| int_mode_i | input | 1 | 1 selects the internal tick, 0 the external clock |
| period_cfg_i | input | TW | Internal switching period in system cycles |
| setpt_i | input | NDLY x SW | Unsigned setpoint per delayed channel |
| gain_i | input | GW | Signed degrees per setpoint unit |
| ph_min_i | input | 9 | Phase at minimum setpoint, degrees |
| ph_max_i | input | 9 | Phase at maximum setpoint, degrees |
| ref_trig_o | output | 1 | Reference trigger strobe |
| dly_trig_o | output | NDLY | Delayed trigger strobes |
| trig_cnt_o | output | (NDLY+1) x CW | Trigger counters, index 0 for the reference |

## Verification
A wrong period register or timer shifts every delayed strobe by the same error from the second period on. It also changes the spacing between reference strobes. A wrong captured phase moves only its own channel, in the first full period after the capture. A stuck or wrong armed flag shows up within one period as a missing or doubled strobe, and as a counter that no longer matches the number of pulses seen at the pins.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int PH_W     = 9;
  localparam int PH_LIMIT = 359;
  localparam int DEG_FULL = 360;
  typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/pst_master_src.sv
module pst_master_src #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk_i,
  input  logic          int_mode_i,
  input  logic [TW-1:0] period_cfg_i,
  output logic          rise_o
);
  logic [1:0]    sync_q;
  logic [TW-1:0] icnt_q;
  logic          tick_q;
  logic          mst_q;
  logic          mst;
  logic          tick_due;

  assign tick_due = ({1'b0, icnt_q} + (TW+1)'(1)) >= {1'b0, period_cfg_i};
  assign mst      = int_mode_i ? tick_q : sync_q[1];
  assign rise_o   = mst & ~mst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      icnt_q <= '0;
      tick_q <= 1'b0;
      mst_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ext_clk_i};
      mst_q  <= mst;
      if (tick_due) begin
        icnt_q <= '0;
        tick_q <= 1'b1;
      end else begin
        icnt_q <= icnt_q + TW'(1);
        tick_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pst_phase_map.sv
module pst_phase_map #(
  parameter int SW = 8,
  parameter int GW = 8
) (
  input  logic [SW-1:0]         setpt_i,
  input  logic signed [GW-1:0]  gain_i,
  input  pst_pkg::phase_t       ph_min_i,
  input  pst_pkg::phase_t       ph_max_i,
  output pst_pkg::phase_t       phase_o
);
  import pst_pkg::*;
  localparam int MW = SW + GW + PH_W + 2;

  phase_t              min_c, max_c;
  logic signed [GW:0]  g_in, g_eff;
  logic signed [MW-1:0] sp_s, g_s, min_s, max_s, mapped, lo_s, hi_s, clamped;

  assign min_c = (ph_min_i > phase_t'(PH_LIMIT)) ? phase_t'(PH_LIMIT) : ph_min_i;
  assign max_c = (ph_max_i > phase_t'(PH_LIMIT)) ? phase_t'(PH_LIMIT) : ph_max_i;
  assign g_in  = {gain_i[GW-1], gain_i};

  always_comb begin
    g_eff = g_in;
    if ((max_c > min_c) && (g_in < 0))      g_eff = -g_in;
    else if ((max_c < min_c) && (g_in > 0)) g_eff = -g_in;
  end

  assign sp_s   = {{(MW-SW){1'b0}}, setpt_i};
  assign g_s    = {{(MW-GW-1){g_eff[GW]}}, g_eff};
  assign min_s  = {{(MW-PH_W){1'b0}}, min_c};
  assign max_s  = {{(MW-PH_W){1'b0}}, max_c};
  assign mapped = sp_s * g_s + min_s;
  assign lo_s   = (g_eff >= 0) ? min_s : max_s;
  assign hi_s   = (g_eff >= 0) ? max_s : min_s;

  always_comb begin
    clamped = mapped;
    if (clamped < lo_s) clamped = lo_s;
    if (clamped > hi_s) clamped = hi_s;
  end

  assign phase_o = clamped[PH_W-1:0];
endmodule

// File: rtl/pst_delay_chan.sv
module pst_delay_chan #(
  parameter int TW = 16,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise_i,
  input  pst_pkg::phase_t phase_i,
  input  logic [TW-1:0]   period_i,
  input  logic [TW-1:0]   timer_i,
  output logic            trig_o,
  output logic [CW-1:0]   cnt_o
);
  import pst_pkg::*;
  localparam int XW = TW + PH_W;

  phase_t        phase_q;
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [XW-1:0] prod, delay;
  logic          fire;

  assign prod  = {{PH_W{1'b0}}, period_i} * {{TW{1'b0}}, phase_q};
  assign delay = prod / XW'(DEG_FULL);
  assign fire  = armed_q && ({{PH_W{1'b0}}, timer_i} >= delay);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (rise_i) phase_q <= phase_i;
      if (rise_i)    armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
      if (fire) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign trig_o = fire;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pst_trigger_ctrl.sv
module pst_trigger_ctrl #(
  parameter int TW   = 16,
  parameter int SW   = 8,
  parameter int GW   = 8,
  parameter int CW   = 16,
  parameter int NDLY = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ext_clk_i,
  input  logic                      int_mode_i,
  input  logic [TW-1:0]             period_cfg_i,
  input  logic [NDLY-1:0][SW-1:0]   setpt_i,
  input  logic signed [GW-1:0]      gain_i,
  input  logic [8:0]                ph_min_i,
  input  logic [8:0]                ph_max_i,
  output logic                      ref_trig_o,
  output logic [NDLY-1:0]           dly_trig_o,
  output logic [NDLY:0][CW-1:0]     trig_cnt_o
);
  import pst_pkg::*;

  logic                       rise;
  logic [TW-1:0]              timer_q, period_q;
  logic                       ref_q;
  logic [CW-1:0]              ref_cnt_q;
  logic [NDLY-1:0][PH_W-1:0]  map_ph;

  pst_master_src #(.TW(TW)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i),
    .int_mode_i(int_mode_i), .period_cfg_i(period_cfg_i), .rise_o(rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q   <= '0;
      period_q  <= '0;
      ref_q     <= 1'b0;
      ref_cnt_q <= '0;
    end else begin
      ref_q <= rise;
      if (rise) begin
        period_q <= (timer_q == '1) ? timer_q : timer_q + TW'(1);
        timer_q  <= '0;
      end else if (timer_q != '1) begin
        timer_q  <= timer_q + TW'(1);
      end
      if (ref_q) ref_cnt_q <= ref_cnt_q + CW'(1);
    end
  end

  assign ref_trig_o    = ref_q;
  assign trig_cnt_o[0] = ref_cnt_q;

  for (genvar k = 0; k < NDLY; k++) begin : g_chan
    pst_phase_map #(.SW(SW), .GW(GW)) u_map (
      .setpt_i(setpt_i[k]), .gain_i(gain_i),
      .ph_min_i(ph_min_i), .ph_max_i(ph_max_i), .phase_o(map_ph[k])
    );
    pst_delay_chan #(.TW(TW), .CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .phase_i(map_ph[k]),
      .period_i(period_q), .timer_i(timer_q),
      .trig_o(dly_trig_o[k]), .cnt_o(trig_cnt_o[k+1])
    );
  end
endmodule

// File: rtl/pst_trigger_chk.sv
module pst_trigger_chk #(
  parameter int NDLY = 3,
  parameter int CW   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ref_trig,
  input logic [NDLY-1:0]         dly_trig,
  input logic [NDLY:0][CW-1:0]   trig_cnt,
  input logic [NDLY-1:0][8:0]    map_ph
);
  logic [NDLY:0]   all_trig;
  logic [NDLY-1:0] seen_q;
  logic            ref_seen_q;

  assign all_trig = {dly_trig, ref_trig};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= '0;
      ref_seen_q <= 1'b0;
    end else begin
      seen_q     <= ref_trig ? dly_trig : (seen_q | dly_trig);
      if (ref_trig) ref_seen_q <= 1'b1;
    end
  end

  AST_REF_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_trig |=> !ref_trig); // R2

  for (genvar k = 0; k < NDLY; k++) begin : g_dly
    AST_DLY_ONCE_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      !(dly_trig[k] && seen_q[k] && !ref_trig)); // R8
    AST_DLY_AFTER_FIRST_REF: assert property (@(posedge clk) disable iff (!rst_n)
      dly_trig[k] |-> (ref_seen_q || ref_trig)); // R10
    AST_PHASE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      map_ph[k] <= 9'd359); // R5
  end

  for (genvar c = 0; c <= NDLY; c++) begin : g_cnt
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      all_trig[c] |=> (trig_cnt[c] == $past(trig_cnt[c]) + CW'(1))); // R9
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !all_trig[c] |=> $stable(trig_cnt[c])); // R9
  end
endmodule

bind pst_trigger_ctrl pst_trigger_chk #(.NDLY(NDLY), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_trig(ref_trig_o), .dly_trig(dly_trig_o),
  .trig_cnt(trig_cnt_o), .map_ph(map_ph)
);

// File: tb/tb_pst_trigger_ctrl.sv
module tb_pst_trigger_ctrl;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ext_clk = 1'b0;
  logic              int_mode = 1'b1;
  logic [15:0]       period_cfg = 16'd90;
  logic [2:0][7:0]   setpt = '0;
  logic signed [7:0] gain = '0;
  logic [8:0]        ph_min = '0, ph_max = '0;
  logic              ref_trig;
  logic [2:0]        dly_trig;
  logic [3:0][15:0]  trig_cnt;

  pst_trigger_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .int_mode_i(int_mode),
    .period_cfg_i(period_cfg), .setpt_i(setpt), .gain_i(gain),
    .ph_min_i(ph_min), .ph_max_i(ph_max), .ref_trig_o(ref_trig),
    .dly_trig_o(dly_trig), .trig_cnt_o(trig_cnt)
  );

  always #10 clk = ~clk; // 50 MHz

  int n_chk = 0, n_fail = 0;
  bit ext_run = 1'b0;
  bit finished = 1'b0;

  // Stimulus / expected table: period, setpoints, gain, bounds, expected phases
  localparam int ROWS = 5;
  localparam int T_P   [ROWS] = '{90, 120, 100, 72, 144};
  localparam int T_S0  [ROWS] = '{10, 0, 5, 0, 80};
  localparam int T_S1  [ROWS] = '{20, 50, 40, 50, 71};
  localparam int T_S2  [ROWS] = '{30, 200, 100, 100, 0};
  localparam int T_G   [ROWS] = '{3, 2, -2, 3, 5};
  localparam int T_MIN [ROWS] = '{0, 10, 10, 300, 0};
  localparam int T_MAX [ROWS] = '{300, 180, 180, 60, 500};
  localparam int T_E0  [ROWS] = '{30, 10, 20, 300, 359};
  localparam int T_E1  [ROWS] = '{60, 110, 90, 150, 355};
  localparam int T_E2  [ROWS] = '{90, 180, 180, 60, 0};
  localparam string T_REQ [ROWS] = '{"R5", "R7", "R6", "R6/R7 neg", "R5 cap"};

  // Pin monitor
  int cyc, ref_cyc, nref, tot_ref, snap_len;
  int off [3], npul [3], tot [3], snap_off [3], snap_n [3];
  bit early;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; ref_cyc = 0; nref = 0; tot_ref = 0; early = 1'b0;
      for (int k = 0; k < 3; k++) begin off[k] = 0; npul[k] = 0; tot[k] = 0; end
    end else begin
      cyc++;
      if (ref_trig) begin
        snap_len = cyc - ref_cyc;
        for (int k = 0; k < 3; k++) begin
          snap_off[k] = off[k]; snap_n[k] = npul[k]; npul[k] = 0;
        end
        ref_cyc = cyc; nref++; tot_ref++;
      end
      for (int k = 0; k < 3; k++)
        if (dly_trig[k]) begin
          if (nref == 0) early = 1'b1;
          off[k] = cyc - ref_cyc; npul[k]++; tot[k]++;
        end
    end
  end

  always begin
    if (ext_run) begin
      ext_clk = 1'b1; repeat (32) @(negedge clk);
      ext_clk = 1'b0; repeat (32) @(negedge clk);
    end else @(negedge clk);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_refs(input int n);
    int tgt;
    tgt = nref + n;
    while (nref < tgt) begin @(posedge clk); #2; end
  endtask

  task automatic check_period(input int p, input int e0, input int e1, input int e2,
                              input string req);
    int ex [3];
    ex[0] = (p * e0) / 360; ex[1] = (p * e1) / 360; ex[2] = (p * e2) / 360;
    chk(snap_len == p, "R1/R3 period", snap_len, p);
    for (int k = 0; k < 3; k++) begin
      chk(snap_off[k] == ex[k], {req, " R3 delay"}, snap_off[k], ex[k]);
      chk(snap_n[k] == 1, "R8 once per period", snap_n[k], 1);
    end
  endtask

  task automatic check_counts();
    chk(int'(trig_cnt[0]) == tot_ref, "R9 ref count", int'(trig_cnt[0]), tot_ref);
    for (int k = 0; k < 3; k++)
      chk(int'(trig_cnt[k+1]) == tot[k], "R9 delayed count", int'(trig_cnt[k+1]), tot[k]);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2;
    // R10: reset state
    chk(ref_trig == 1'b0, "R10 ref low in reset", ref_trig, 0);
    chk(dly_trig == 3'b0, "R10 delayed low in reset", dly_trig, 0);
    chk(trig_cnt == '0, "R10 counters clear", int'(trig_cnt[1]), 0);
    rst_n = 1'b1;

    // Table walk in internal mode (R1)
    for (int i = 0; i < ROWS; i++) begin
      int_mode   = 1'b1;
      period_cfg = 16'(T_P[i]);
      setpt[0] = 8'(T_S0[i]); setpt[1] = 8'(T_S1[i]); setpt[2] = 8'(T_S2[i]);
      gain   = 8'(T_G[i]);
      ph_min = 9'(T_MIN[i]);
      ph_max = 9'(T_MAX[i]);
      wait_refs(4);
      check_period(T_P[i], T_E0[i], T_E1[i], T_E2[i], T_REQ[i]);
      check_counts();
    end
    chk(early == 1'b0, "R10 no delayed trigger before first reference", early, 0);

    // External clock mode, period 64 (R1)
    setpt[0] = 8'd10; setpt[1] = 8'd20; setpt[2] = 8'd30;
    gain = 8'sd3; ph_min = 9'd0; ph_max = 9'd300;
    ext_run = 1'b1;
    int_mode = 1'b0;
    wait_refs(4);
    check_period(64, 30, 60, 90, "R1 ext");

    // R4: setpoint change inside a period is ignored until the next edge
    wait_refs(1);
    setpt[0] = 8'd100; setpt[1] = 8'd100; setpt[2] = 8'd100;
    wait_refs(1);
    check_period(64, 30, 60, 90, "R4 held");
    wait_refs(1);
    check_period(64, 300, 300, 300, "R4 applied");
    check_counts();

    // R10: reset in mid-run clears counters and silences triggers
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(trig_cnt == '0, "R10 counters clear after reset", int'(trig_cnt[0]), 0);
    chk(ref_trig == 1'b0 && dly_trig == 3'b0, "R10 triggers low after reset",
        {ref_trig, dly_trig}, 0);
    ext_run = 1'b0;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", nref, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule